// File: doc/BRIEF.md
# Facilities Data Link Remote Alarm Detector

This block watches the bit stream of the facilities data link (FDL) carried in an extended-superframe T1/J1 receiver. It raises a remote alarm indication, the yellow alarm, once it has recognised the alarm codeword often enough. It drops the alarm again once the codeword has become scarce. The framer upstream presents one FDL bit per accepted transfer. The block has no framing, superframe extraction or message decoding of its own.

A mode pin selects one of two 16-bit codewords. The standard word is a run of eight ones followed by eight zeros. The J1 word is sixteen ones. The two rules are deliberately asymmetric. Sixteen back-to-back codeword slots turn the alarm on. While the alarm is on, it turns off as soon as the most recent 16 slots hold 14 codewords or fewer.

The input is a valid/ready stream. `fdl_ready` is held high, so the block never applies back-pressure, and a bit is consumed on every clock where `fdl_valid` is high. Upstream may leave any number of idle cycles between bits. The status outputs are plain levels and pulses.

Top module: `yad_fdl_alarm`

## Requirements
- R1: After a synchronous active-high reset, `alarm` and `alarm_chg` are low, the slot history is empty (all misses), and the run counter is zero.
- R2: In standard mode (`mode_jp`=0) the codeword is 0xFF00, taken with the first-received bit as the most significant bit. When a slot holds the codeword, that slot is a hit. Sixteen consecutive hits set `alarm` one clock after the edge that accepts the last bit of the sixteenth codeword.
- R3: In standard mode the block finds alignment by itself. The codeword is recognised at any bit offset, including after stray bits. Each recognised codeword starts a new 16-bit slot. If 16 bits pass without a match, a miss slot is recorded.
- R4: In J1 mode (`mode_jp`=1) the codeword is 0xFFFF. Slots lie on fixed 16-bit boundaries, counted from the first accepted bit after reset or after a mode change. Sixteen consecutive hits set `alarm`.
- R5: Any miss sets the consecutive-hit count back to zero. Fifteen hits followed by a miss do not set the alarm.
- R6: While `alarm` is high, it is cleared once the last 16 slots contain 14 or fewer hits. A single miss among them does not clear it.
- R7: `alarm_chg` is high for exactly the clock in which `alarm` differs from its value in the previous clock, on both rising and falling changes.
- R8: A change of `mode_jp` clears `alarm`, the history, the run counter and the slot alignment at the next edge. An FDL bit offered in that same cycle is discarded.
- R9: `fdl_ready` is always high. Cycles with `fdl_valid` low leave the detection state unchanged.
- R10: In standard mode a 0xFFFF slot is a miss. In J1 mode a 0xFF00 slot is a miss.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mode_jp | input | 1 | 0: standard codeword 0xFF00, 1: J1 codeword 0xFFFF |
| fdl_valid | input | 1 | An FDL bit is offered |
| fdl_bit | input | 1 | FDL data bit |
| fdl_ready | output | 1 | Always high; the block accepts every offered bit |
| alarm | output | 1 | Remote alarm status level |
| alarm_chg | output | 1 | One-clock pulse when `alarm` changes |

## Verification
The hardest behaviour to reach from the ports is hysteresis at the exact threshold. Clearing needs a second miss while the first miss is still inside the 16-slot window, and J1 detection has to fail when alignment is off by a single bit. The stimulus first sets the alarm, then sends one miss, three hits and a second miss, and checks the level before and after. For J1 it sends one stray bit ahead of sixteen all-ones words. That leaves exactly fifteen aligned hits, so only a seventeenth word may raise the alarm. Idle gaps between bits and a mode change in the same cycle as a valid bit are mixed into the run. A behavioural model compares against this on every clock.

// File: rtl/yad_pkg.sv
package yad_pkg;
  // Result of one pattern slot
  typedef struct packed {
    logic slot_end;  // a slot closed on this accepted bit
    logic hit;       // the closed slot held the codeword
  } slot_t;

  typedef enum logic {
    ST_CLEAR = 1'b0,
    ST_SET   = 1'b1
  } alarm_st_t;
endpackage

// File: rtl/yad_aligner.sv
module yad_aligner
  import yad_pkg::*;
#(
  parameter int PAT_W = 16
) (
  input  logic  clk,
  input  logic  rst,
  input  logic  flush,
  input  logic  mode_jp,
  input  logic  in_valid,
  input  logic  in_bit,
  output slot_t slot
);
  localparam int CW = $clog2(PAT_W);
  localparam int HALF = PAT_W / 2;
  localparam logic [PAT_W-1:0] STD_WORD = {{HALF{1'b1}}, {(PAT_W-HALF){1'b0}}};
  localparam logic [PAT_W-1:0] JP_WORD  = '1;
  localparam logic [CW-1:0]    LAST_POS = CW'(PAT_W - 1);

  logic [PAT_W-1:0] sh, sh_nx;
  logic [CW-1:0]    pos;
  logic             at_last, std_match, jp_match;

  always_comb begin
    sh_nx     = {sh[PAT_W-2:0], in_bit};
    at_last   = (pos == LAST_POS);
    std_match = (sh_nx == STD_WORD);
    jp_match  = (sh_nx == JP_WORD);
    if (mode_jp) begin
      // fixed boundaries
      slot.slot_end = in_valid && at_last;
      slot.hit      = in_valid && at_last && jp_match;
    end else begin
      // realign on every match
      slot.slot_end = in_valid && (at_last || std_match);
      slot.hit      = in_valid && std_match;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      sh  <= '0;
      pos <= '0;
    end else if (in_valid) begin
      sh  <= sh_nx;
      pos <= slot.slot_end ? '0 : pos + 1'b1;
    end
  end

  // R3: a hit always closes a slot
  assert_hit_closes_slot_R3: assert property (@(posedge clk) disable iff (rst)
    slot.hit |-> slot.slot_end);
endmodule

// File: rtl/yad_window.sv
module yad_window
  import yad_pkg::*;
#(
  parameter int WIN     = 16,
  parameter int SET_CNT = 16,
  parameter int CLR_MAX = 14
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           flush,
  input  slot_t          slot,
  output logic [WIN-1:0] hist,
  output logic           set_cond,
  output logic           clr_cond
);
  localparam int CCW = $clog2(SET_CNT + 1);
  localparam int PW  = $clog2(WIN + 1);

  logic [CCW-1:0] consec;
  logic [PW-1:0]  pop;

  always_comb begin
    pop = '0;
    for (int i = 0; i < WIN; i++) pop = pop + PW'(hist[i]);
  end

  assign set_cond = (consec == CCW'(SET_CNT));
  assign clr_cond = (pop <= PW'(CLR_MAX));

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      hist   <= '0;
      consec <= '0;
    end else if (slot.slot_end) begin
      hist <= {hist[WIN-2:0], slot.hit};
      if (!slot.hit)                      consec <= '0;
      else if (consec != CCW'(SET_CNT))   consec <= consec + 1'b1;
    end
  end

  // R2: a full run is always backed by the history
  assert_run_in_history_R2: assert property (@(posedge clk) disable iff (rst)
    (consec == CCW'(SET_CNT)) |-> ($countones(hist) >= SET_CNT));

  // R8: a mode flush empties history and run counter
  assert_flush_empties_R8: assert property (@(posedge clk) disable iff (rst)
    flush |=> (hist == '0 && consec == '0));
endmodule

// File: rtl/yad_alarm_fsm.sv
module yad_alarm_fsm
  import yad_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic flush,
  input  logic set_cond,
  input  logic clr_cond,
  output logic alarm,
  output logic alarm_chg
);
  alarm_st_t st, st_nx;

  always_comb begin
    st_nx = st;
    if (flush)                        st_nx = ST_CLEAR;
    else if (st == ST_CLEAR && set_cond) st_nx = ST_SET;
    else if (st == ST_SET && clr_cond)   st_nx = ST_CLEAR;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_CLEAR;
      alarm_chg <= 1'b0;
    end else begin
      st        <= st_nx;
      alarm_chg <= (st_nx != st);
    end
  end

  assign alarm = (st == ST_SET);
endmodule

// File: rtl/yad_fdl_alarm.sv
module yad_fdl_alarm
  import yad_pkg::*;
#(
  parameter int PAT_W   = 16,
  parameter int WIN     = 16,
  parameter int SET_CNT = 16,
  parameter int CLR_MAX = 14
) (
  input  logic clk,
  input  logic rst,
  input  logic mode_jp,
  input  logic fdl_valid,
  input  logic fdl_bit,
  output logic fdl_ready,
  output logic alarm,
  output logic alarm_chg
);
  logic           mode_q, mode_chg, take;
  slot_t          slot;
  logic [WIN-1:0] hist;
  logic           set_cond, clr_cond;

  always_ff @(posedge clk) begin
    mode_q <= mode_jp;
  end

  // after reset mode_q already equals mode_jp, so reset masks any stale compare
  assign mode_chg  = !rst && (mode_jp != mode_q);
  assign take      = fdl_valid && !mode_chg;
  assign fdl_ready = 1'b1;

  yad_aligner #(.PAT_W(PAT_W)) u_align (
    .clk(clk), .rst(rst), .flush(mode_chg), .mode_jp(mode_jp),
    .in_valid(take), .in_bit(fdl_bit), .slot(slot)
  );

  yad_window #(.WIN(WIN), .SET_CNT(SET_CNT), .CLR_MAX(CLR_MAX)) u_win (
    .clk(clk), .rst(rst), .flush(mode_chg), .slot(slot),
    .hist(hist), .set_cond(set_cond), .clr_cond(clr_cond)
  );

  yad_alarm_fsm u_fsm (
    .clk(clk), .rst(rst), .flush(mode_chg), .set_cond(set_cond),
    .clr_cond(clr_cond), .alarm(alarm), .alarm_chg(alarm_chg)
  );

  // R5: the alarm rises only on a history of full hits
  assert_set_needs_run_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(alarm) |-> ($countones($past(hist)) >= SET_CNT));

  // R6: apart from a mode flush, the alarm falls only on a thinned history
  assert_clear_rule_R6: assert property (@(posedge clk) disable iff (rst)
    $fell(alarm) |-> ($past(mode_chg) || $countones($past(hist)) <= CLR_MAX));

  // R7: the change pulse marks exactly the clocks where the level moved
  assert_chg_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    alarm_chg == (alarm != $past(alarm)));

  // R8: a mode change leaves the alarm cleared
  assert_mode_clears_R8: assert property (@(posedge clk) disable iff (rst)
    mode_chg |=> !alarm);
endmodule

// File: tb/tb_yad_fdl_alarm.sv
`timescale 1ns/1ps
module tb_yad_fdl_alarm;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst, mode_jp, fdl_valid, fdl_bit;
  logic fdl_ready, alarm, alarm_chg;

  yad_fdl_alarm dut (
    .clk(clk), .rst(rst), .mode_jp(mode_jp), .fdl_valid(fdl_valid),
    .fdl_bit(fdl_bit), .fdl_ready(fdl_ready), .alarm(alarm), .alarm_chg(alarm_chg)
  );

  int checks = 0;
  int failures = 0;
  string req = "R1";
  bit done = 0;

  // behavioural reference
  int m_sh, m_cnt, m_consec, m_pc;
  bit m_hist[$];
  bit m_alarm, m_chg, m_mode_q, m_prev, m_end, m_hit;
  int m_pat;

  task automatic check(bit ok, string r, string what, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d t=%0t", r, what, act, exp, $time);
    end
  endtask

  task automatic m_flush();
    m_sh = 0; m_cnt = 0; m_consec = 0;
    m_hist.delete();
    for (int i = 0; i < 16; i++) m_hist.push_back(1'b0);
  endtask

  always @(posedge clk) begin
    m_prev = m_alarm;
    if (rst) begin
      m_flush();
      m_alarm = 0;
      m_mode_q = mode_jp;
      m_chg = 0;
    end else begin
      if (mode_jp != m_mode_q) begin
        m_flush();
        m_alarm = 0;
      end else begin
        m_pc = 0;
        foreach (m_hist[i]) m_pc += m_hist[i];
        if (!m_alarm && m_consec >= 16) m_alarm = 1;
        else if (m_alarm && m_pc <= 14) m_alarm = 0;
        if (fdl_valid) begin
          m_sh = ((m_sh << 1) | fdl_bit) & 16'hFFFF;
          m_pat = mode_jp ? 16'hFFFF : 16'hFF00;
          m_end = (m_cnt == 15) || (!mode_jp && m_sh == m_pat);
          if (m_end) begin
            m_hit = (m_sh == m_pat);
            m_hist.push_back(m_hit);
            void'(m_hist.pop_front());
            m_consec = m_hit ? ((m_consec < 16) ? m_consec + 1 : 16) : 0;
            m_cnt = 0;
          end else m_cnt++;
        end
      end
      m_mode_q = mode_jp;
      m_chg = (m_alarm != m_prev);
    end
  end

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (!done && !rst) begin
      check(alarm === m_alarm, req, "alarm", alarm, m_alarm);
      check(alarm_chg === m_chg, req, "alarm_chg", alarm_chg, m_chg);
      check(fdl_ready === 1'b1, "R9", "fdl_ready", fdl_ready, 1);
    end
  end

  task automatic idle(int n);
    repeat (n) begin
      @(negedge clk);
      fdl_valid = 0;
      fdl_bit = 1'($urandom);
    end
  endtask

  task automatic send_bit(bit b, int gap);
    if (gap > 0) idle(gap);
    @(negedge clk);
    fdl_valid = 1;
    fdl_bit = b;
  endtask

  task automatic send_words(logic [15:0] w, int n, int gap);
    for (int k = 0; k < n; k++)
      for (int i = 15; i >= 0; i--) send_bit(w[i], gap);
  endtask

  task automatic expect_alarm(bit exp, string r, string what);
    idle(3);
    check(alarm === exp, r, what, alarm, exp);
  endtask

  initial begin
    rst = 1; mode_jp = 0; fdl_valid = 0; fdl_bit = 0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(alarm === 1'b0, "R1", "alarm in reset", alarm, 0);
    check(alarm_chg === 1'b0, "R1", "alarm_chg in reset", alarm_chg, 0);
    rst = 0;
    idle(2);

    // R5: fifteen hits then a miss do not set; run restarts
    req = "R5";
    send_words(16'hFF00, 15, 0);
    send_words(16'h0000, 1, 0);
    send_words(16'hFF00, 15, 0);
    expect_alarm(0, "R5", "15 hits after miss");
    // R2: sixteenth consecutive hit sets
    req = "R2";
    send_words(16'hFF00, 1, 0);
    expect_alarm(1, "R2", "16 consecutive std codewords");

    // R6: one miss keeps, second miss inside window clears
    req = "R6";
    send_words(16'h0000, 1, 0);
    send_words(16'hFF00, 3, 0);
    expect_alarm(1, "R6", "single miss keeps alarm");
    send_words(16'h0000, 1, 0);
    expect_alarm(0, "R6", "14 of 16 clears alarm");

    // R3 + R9: stray bits, then codewords with idle gaps
    req = "R3";
    send_bit(1, 0); send_bit(0, 0); send_bit(1, 0); send_bit(0, 0); send_bit(0, 0);
    send_words(16'hFF00, 16, 2);
    expect_alarm(1, "R3", "misaligned std codewords with gaps");
    req = "R9";
    idle(40);
    check(alarm === 1'b1, "R9", "idle cycles change nothing", alarm, 1);

    // R10: all-ones is a miss in standard mode
    req = "R10";
    send_words(16'hFFFF, 20, 0);
    expect_alarm(0, "R10", "0xFFFF in std mode");

    // R8: mode change while set clears it, bit in that cycle dropped
    req = "R8";
    send_words(16'hFF00, 16, 0);
    expect_alarm(1, "R8", "set before mode change");
    @(negedge clk);
    mode_jp = 1; fdl_valid = 1; fdl_bit = 1;
    @(negedge clk);
    fdl_valid = 0;
    check(alarm === 1'b0, "R8", "alarm after mode change", alarm, 0);
    check(alarm_chg === 1'b1, "R7", "pulse on mode clear", alarm_chg, 1);
    @(negedge clk);
    check(alarm_chg === 1'b0, "R7", "pulse lasts one clock", alarm_chg, 0);

    // R4: one stray bit misaligns J1 slots
    req = "R4";
    send_bit(0, 0);
    send_words(16'hFFFF, 16, 0);
    expect_alarm(0, "R4", "misaligned J1 gives 15 hits");
    send_words(16'hFFFF, 1, 1);
    expect_alarm(1, "R4", "17th J1 word sets");

    // R10: standard word misses in J1 mode; two misses clear
    req = "R10";
    send_words(16'hFF00, 20, 0);
    expect_alarm(0, "R10", "0xFF00 in J1 mode");

    // R8 + R4: back to standard then J1 aligned from scratch
    req = "R8";
    @(negedge clk); mode_jp = 0; fdl_valid = 0;
    idle(2);
    @(negedge clk); mode_jp = 1;
    req = "R4";
    send_words(16'hFFFF, 16, 0);
    expect_alarm(1, "R4", "aligned J1 16 words");

    idle(5);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      failures++;
      $display("FAIL watchdog R1 actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule